// File: doc/BRIEF.md
# Rollback-Capable Synchronous FIFO

This block is a single-clock first-in first-out queue with a valid/ready handshake on the producer port and on the consumer port. Either port can be built as transactional. A transactional producer may write a group of words and then publish or cancel them as a unit. A transactional consumer may read ahead and then release the space it has read, or rewind and read the same words again.

Each port keeps two pointers, one speculative and one committed. New words stay hidden from the consumer until a producer commit moves the committed write pointer. Space the consumer has read is not returned to the producer until a consumer commit moves the committed read pointer. The full indication compares the speculative write pointer with the committed read pointer. The empty indication compares the speculative read pointer with the committed write pointer. A port built without the transactional option moves its committed pointer together with its speculative pointer, so that port behaves like an ordinary FIFO. DEPTH must be a power of two.

Top module: `txfifo_xact`

## Requirements
- R1: A word moves on a port in every cycle where that port's valid and ready are both high, and the consumer receives words in the order they were written.
- R2: On a transactional producer, written words stay invisible (`out_valid` low) until `wr_commit`; a commit raised in the same cycle as a write includes that write, and `out_valid` is high in the following cycle.
- R3: A `wr_abort` pulse discards every write since the last producer commit, including a write in the same cycle; `in_ready` is high in the cycle after the abort, even if the FIFO was full.
- R4: On a transactional consumer, reads without `rd_commit` return no space: after the consumer reads every word of a full FIFO, `in_ready` is low and `out_valid` is low.
- R5: A `rd_abort` pulse returns the read position to the last consumer commit, and the same words are delivered again in the same order.
- R6: A `rd_commit` raised with the last read of a group frees all space read so far, so `in_ready` is high in the next cycle.
- R7: When abort and commit are raised together on one port, the abort takes effect and the commit is ignored.
- R8: On a port built without the transactional option, its commit and abort inputs have no effect: writes become visible at once and reads free space at once.
- R9: Synchronous active-high reset clears all four pointers, so `out_valid` is low and `in_ready` is high.
- R10: `in_ready` goes low when DEPTH words are held between the committed read pointer and the speculative write pointer.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer has a word |
| in_ready | output | 1 | FIFO can accept a word |
| in_data | input | WIDTH | Producer word |
| wr_commit | input | 1 | Publish all pending writes, including this cycle's write |
| wr_abort | input | 1 | Drop all unpublished writes |
| out_valid | output | 1 | A published word is available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | WIDTH | Word at the read position |
| rd_commit | input | 1 | Release the space of all words read, including this cycle's read |
| rd_abort | input | 1 | Rewind the read position to the last consumer commit |

## Verification
Short bursts with a commit on the last word show that a same-cycle commit is included, and that words without a commit stay hidden. A full burst without a commit followed by an abort shows that `in_ready` comes back at once. A full published burst read without a consumer commit, then rewound and read again, separates read position from reclaimed space. Pulses that raise abort and commit together show which one has priority. A second instance built without the transactional option is driven with its abort inputs held high, which shows that those inputs do nothing there.

// File: rtl/txfifo_pkg.sv
package txfifo_pkg;

    // Per-cycle request seen by one pointer pair
    typedef struct packed {
        logic xfer;    // a word moves on this port this cycle
        logic commit;  // publish / release up to and including xfer
        logic abort;   // roll speculative pointer back to committed
    } side_ctl_s;

    // Resolved action on the speculative pointer
    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_ADV    = 2'd1,
        STEP_REWIND = 2'd2
    } step_e;

    function automatic step_e pick_step(side_ctl_s c, bit xact);
        if (xact && c.abort) return STEP_REWIND;
        if (c.xfer)          return STEP_ADV;
        return STEP_HOLD;
    endfunction

endpackage

// File: rtl/txfifo_ptr_pair.sv
module txfifo_ptr_pair
    import txfifo_pkg::*;
#(
    parameter int AW   = 5,
    parameter bit XACT = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  side_ctl_s       ctl,
    output logic [AW:0]     spec,
    output logic [AW:0]     cmt
);
    logic [AW:0] spec_n, cmt_n;
    step_e       step;

    assign step = pick_step(ctl, XACT);

    always_comb begin
        unique case (step)
            STEP_REWIND: spec_n = cmt;
            STEP_ADV:    spec_n = spec + {{AW{1'b0}}, 1'b1};
            default:     spec_n = spec;
        endcase
    end

    generate
        if (XACT) begin : g_xact
            always_comb begin
                if (step == STEP_REWIND)
                    cmt_n = cmt;
                else if (ctl.commit)
                    cmt_n = spec_n;
                else
                    cmt_n = cmt;
            end
        end else begin : g_plain
            logic unused_ctl;
            assign unused_ctl = ctl.commit ^ ctl.abort;
            always_comb cmt_n = spec_n;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            spec <= '0;
            cmt  <= '0;
        end else begin
            spec <= spec_n;
            cmt  <= cmt_n;
        end
    end

endmodule

// File: rtl/txfifo_store.sv
module txfifo_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/txfifo_xact.sv
module txfifo_xact
    import txfifo_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int DEPTH   = 32,
    parameter bit WR_XACT = 1'b1,
    parameter bit RD_XACT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    input  logic             wr_commit,
    input  logic             wr_abort,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data,
    input  logic             rd_commit,
    input  logic             rd_abort
);
    localparam int AW = $clog2(DEPTH);

    logic [AW:0] wr_spec, wr_cmt, rd_spec, rd_cmt;
    logic        push, pop;
    side_ctl_s   wctl, rctl;

    // full: speculative writes have lapped the committed read position
    assign in_ready  = !((wr_spec[AW] != rd_cmt[AW]) &&
                         (wr_spec[AW-1:0] == rd_cmt[AW-1:0]));
    // empty: reader has caught up with published writes
    assign out_valid = (rd_spec != wr_cmt);

    assign push = in_valid  && in_ready;
    assign pop  = out_valid && out_ready;

    assign wctl = '{xfer: push, commit: wr_commit, abort: wr_abort};
    assign rctl = '{xfer: pop,  commit: rd_commit, abort: rd_abort};

    txfifo_ptr_pair #(.AW(AW), .XACT(WR_XACT)) u_wptr (
        .clk  (clk),
        .rst  (rst),
        .ctl  (wctl),
        .spec (wr_spec),
        .cmt  (wr_cmt)
    );

    txfifo_ptr_pair #(.AW(AW), .XACT(RD_XACT)) u_rptr (
        .clk  (clk),
        .rst  (rst),
        .ctl  (rctl),
        .spec (rd_spec),
        .cmt  (rd_cmt)
    );

    txfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (wr_spec[AW-1:0]),
        .wdata (in_data),
        .raddr (rd_spec[AW-1:0]),
        .rdata (out_data)
    );

endmodule

// File: rtl/txfifo_xact_chk.sv
module txfifo_xact_chk #(
    parameter int WIDTH   = 16,
    parameter int DEPTH   = 32,
    parameter int AW      = 5,
    parameter bit WR_XACT = 1'b1,
    parameter bit RD_XACT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             wr_commit,
    input logic             wr_abort,
    input logic             out_valid,
    input logic             out_ready,
    input logic [WIDTH-1:0] out_data,
    input logic             rd_commit,
    input logic             rd_abort,
    input logic [AW:0]      wr_spec,
    input logic [AW:0]      rd_spec,
    input logic [AW:0]      rd_cmt
);
    logic [AW:0] held;
    logic        unused_chk;
    assign held       = wr_spec - rd_cmt;
    assign unused_chk = ^{in_valid, wr_commit, wr_abort, rd_commit, rd_abort};

    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    a_r10_occ_bound: assert property (@(posedge clk) disable iff (rst)
        held <= (AW+1)'(DEPTH));

    a_r11_hold_data: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !rd_abort) |=> (out_valid && $stable(out_data)));

    generate
        if (WR_XACT) begin : g_wr
            a_r3_abort_ready: assert property (@(posedge clk) disable iff (rst)
                wr_abort |=> in_ready);
            a_r2_hidden: assert property (@(posedge clk) disable iff (rst)
                (!out_valid && !wr_commit && !rd_abort) |=> !out_valid);
            a_r7_wr_abort_wins: assert property (@(posedge clk) disable iff (rst)
                (!out_valid && wr_abort && !rd_abort) |=> !out_valid);
        end else begin : g_wr_plain
            a_r8_plain_visible: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_ready) |=> out_valid);
        end
        if (RD_XACT) begin : g_rd
            a_r5_rewind: assert property (@(posedge clk) disable iff (rst)
                rd_abort |=> (rd_spec == $past(rd_cmt)));
            a_r4_no_reclaim: assert property (@(posedge clk) disable iff (rst)
                (!in_ready && !rd_commit && !(WR_XACT && wr_abort)) |=> !in_ready);
        end
    endgenerate

endmodule

bind txfifo_xact txfifo_xact_chk #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .WR_XACT(WR_XACT), .RD_XACT(RD_XACT)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .wr_commit(wr_commit), .wr_abort(wr_abort), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .rd_commit(rd_commit),
    .rd_abort(rd_abort), .wr_spec(wr_spec), .rd_spec(rd_spec), .rd_cmt(rd_cmt)
);

// File: tb/txfifo_xact_bench.sv
module txfifo_xact_bench;
    localparam int W = 16;
    localparam int D = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic         in_valid = 0, wr_commit = 0, wr_abort = 0;
    logic         out_ready = 0, rd_commit = 0, rd_abort = 0;
    logic [W-1:0] in_data = '0;
    logic         in_ready, out_valid;
    logic [W-1:0] out_data;

    logic         p_in_valid = 0, p_wr_commit = 0, p_wr_abort = 0;
    logic         p_out_ready = 0, p_rd_commit = 0, p_rd_abort = 0;
    logic [W-1:0] p_in_data = '0;
    logic         p_in_ready, p_out_valid;
    logic [W-1:0] p_out_data;

    txfifo_xact #(.WIDTH(W), .DEPTH(D), .WR_XACT(1'b1), .RD_XACT(1'b1)) u_txfifo_xact (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .wr_commit(wr_commit), .wr_abort(wr_abort),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .rd_commit(rd_commit), .rd_abort(rd_abort)
    );

    txfifo_xact #(.WIDTH(W), .DEPTH(D), .WR_XACT(1'b0), .RD_XACT(1'b0)) u_plain (
        .clk(clk), .rst(rst), .in_valid(p_in_valid), .in_ready(p_in_ready),
        .in_data(p_in_data), .wr_commit(p_wr_commit), .wr_abort(p_wr_abort),
        .out_valid(p_out_valid), .out_ready(p_out_ready), .out_data(p_out_data),
        .rd_commit(p_rd_commit), .rd_abort(p_rd_abort)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard: published words not yet released, and pending writes
    logic [W-1:0] cq[$];
    logic [W-1:0] pq[$];
    int rd_idx = 0;
    int pops   = 0;

    // Monitor: sample mid-cycle what the next rising edge will do
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_abort) begin
                rd_idx = 0;
            end else begin
                if (out_valid && out_ready) begin
                    pops++;
                    if (rd_idx >= cq.size())
                        check(1'b0, "R1 read beyond published data", rd_idx, cq.size());
                    else begin
                        check(out_data == cq[rd_idx], "R1/R5 read order", out_data, cq[rd_idx]);
                        rd_idx++;
                    end
                end
                if (rd_commit) begin
                    repeat (rd_idx) void'(cq.pop_front());
                    rd_idx = 0;
                end
            end
            if (wr_abort) begin
                pq.delete();
            end else begin
                if (in_valid && in_ready) pq.push_back(in_data);
                if (wr_commit) begin
                    cq = {cq, pq};
                    pq.delete();
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_burst(int n, logic [W-1:0] base, bit commit_last);
        for (int i = 0; i < n; i++) begin
            in_valid  = 1'b1;
            in_data   = base + W'(i);
            wr_commit = commit_last && (i == n-1);
            step();
        end
        in_valid  = 1'b0;
        wr_commit = 1'b0;
    endtask

    task automatic rd_burst(int n, bit commit_last);
        for (int i = 0; i < n; i++) begin
            out_ready = 1'b1;
            rd_commit = commit_last && (i == n-1);
            step();
        end
        out_ready = 1'b0;
        rd_commit = 1'b0;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
        check(in_ready == 1'b1,  "R9 reset in_ready", in_ready, 1);
        rst = 1'b0;
        step();

        // R2: hidden until commit; same-cycle commit includes the write
        wr_burst(5, 16'h0100, 1'b0);
        check(out_valid == 1'b0, "R2 uncommitted writes hidden", out_valid, 0);
        wr_burst(1, 16'h0105, 1'b1);
        check(out_valid == 1'b1, "R2 commit with write publishes", out_valid, 1);
        rd_burst(6, 1'b1);
        check(pops == 6, "R1 six words delivered", pops, 6);
        check(out_valid == 1'b0, "R1 empty after group", out_valid, 0);

        // R10 / R3: fill with unpublished data, then abort
        wr_burst(D, 16'h0200, 1'b0);
        check(in_ready == 1'b0, "R10 full at DEPTH", in_ready, 0);
        check(out_valid == 1'b0, "R2 full burst still hidden", out_valid, 0);
        wr_abort = 1'b1;
        step();
        wr_abort = 1'b0;
        check(in_ready == 1'b1, "R3 ready right after abort", in_ready, 1);
        check(out_valid == 1'b0, "R3 aborted words gone", out_valid, 0);

        // R4 / R5 / R6: read all without release, rewind, reread, release
        wr_burst(D, 16'h0300, 1'b1);
        check(in_ready == 1'b0, "R10 full after published burst", in_ready, 0);
        rd_burst(D, 1'b0);
        check(out_valid == 1'b0, "R4 reader sees empty", out_valid, 0);
        check(in_ready == 1'b0, "R4 space not returned", in_ready, 0);
        rd_abort = 1'b1;
        step();
        rd_abort = 1'b0;
        check(out_valid == 1'b1, "R5 data back after rewind", out_valid, 1);
        check(out_data == 16'h0300, "R5 first word again", out_data, 16'h0300);
        rd_burst(D, 1'b1);
        check(in_ready == 1'b1, "R6 space freed by commit", in_ready, 1);
        check(out_valid == 1'b0, "R6 empty after release", out_valid, 0);

        // R7: abort beats commit on each side
        wr_burst(2, 16'h0400, 1'b0);
        wr_commit = 1'b1;
        wr_abort  = 1'b1;
        step();
        wr_commit = 1'b0;
        wr_abort  = 1'b0;
        check(out_valid == 1'b0, "R7 write abort beats commit", out_valid, 0);
        wr_burst(1, 16'h0402, 1'b1);
        check(out_data == 16'h0402, "R7 only later word published", out_data, 16'h0402);
        rd_burst(1, 1'b0);
        rd_commit = 1'b1;
        rd_abort  = 1'b1;
        step();
        rd_commit = 1'b0;
        rd_abort  = 1'b0;
        check(out_valid == 1'b1, "R7 read abort beats commit", out_valid, 1);
        check(out_data == 16'h0402, "R7 word reread", out_data, 16'h0402);
        rd_burst(1, 1'b1);

        // R11: output held while consumer stalls
        wr_burst(2, 16'h0500, 1'b1);
        repeat (3) step();
        check(out_valid == 1'b1, "R11 valid held", out_valid, 1);
        check(out_data == 16'h0500, "R11 data held", out_data, 16'h0500);
        rd_burst(2, 1'b1);
        check(cq.size() == 0, "R1 all published words consumed", cq.size(), 0);

        // R8: plain instance ignores commit/abort (aborts held high)
        p_wr_abort = 1'b1;
        p_rd_abort = 1'b1;
        for (int i = 0; i < D; i++) begin
            p_in_valid = 1'b1;
            p_in_data  = 16'h0600 + W'(i);
            step();
        end
        p_in_valid = 1'b0;
        check(p_in_ready == 1'b0, "R8 plain full", p_in_ready, 0);
        check(p_out_valid == 1'b1, "R8 visible without commit", p_out_valid, 1);
        for (int i = 0; i < D; i++) begin
            check(p_out_valid && (p_out_data == 16'h0600 + W'(i)), "R8 plain order",
                  p_out_data, 16'h0600 + W'(i));
            p_out_ready = 1'b1;
            step();
        end
        p_out_ready = 1'b0;
        check(p_out_valid == 1'b0, "R8 plain empty", p_out_valid, 0);
        check(p_in_ready == 1'b1, "R8 space freed without commit", p_in_ready, 1);

        done = 1;
        report();
        $finish;
    end

endmodule